// File: doc/BRIEF.md
# Fused Shift-Add Integer ALU

A purely combinational 64-bit integer arithmetic unit for the execute stage of a 64-bit core. An operator code and two 64-bit operands go in, and one 64-bit result comes out in the same cycle. The unit holds no state. The operations are add, subtract, signed and unsigned less-than, and left, logical-right and arithmetic-right shifts. Add, subtract and the shifts each come in a full-width form and a 32-bit word form, and every word-form result is sign-extended to 64 bits.

One extra operation merges two steps into a single pass. It shifts the low word of the first operand right logically by a fixed 31 places, which leaves only bit 31 as a 0 or 1. The shared adder then adds that value to the low word of the second operand. The sum is a word sum, sign-extended to 64 bits. Software can then issue one operation in place of a word shift followed by a word add.

Top module: `fsa_alu`

## Requirements
- R1: Code 0 returns op_a + op_b and code 1 returns op_a - op_b, both over 64 bits with wraparound.
- R2: Code 2 (word add) and code 3 (word subtract) work on the low 32 bits of both operands and return the 32-bit result sign-extended from its bit 31. The upper operand bits have no effect.
- R3: Code 4 (shift left), code 5 (logical right) and code 6 (arithmetic right) shift op_a by op_b[5:0]. Higher bits of op_b are ignored.
- R4: Code 7 (word left), code 8 (word logical right) and code 9 (word arithmetic right) shift op_a[31:0] by op_b[4:0] and sign-extend the 32-bit result from its bit 31.
- R5: Code 10 returns 1 when op_a is less than op_b as signed two's-complement values, and 0 otherwise.
- R6: Code 11 returns 1 when op_a is less than op_b as unsigned values, and 0 otherwise.
- R7: Code 12 (fused) returns sign-extend32(op_a[31] + op_b[31:0]). op_a[63:32], op_a[30:0] and op_b[63:32] have no effect.
- R8: Codes 13, 14 and 15 return zero, whatever the operands are.
- R9: The result follows the inputs combinationally, with no clock edge between an input change and the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operator code |
| opa_i | input | 64 | First operand; the value that is shifted |
| opb_i | input | 64 | Second operand; addend, subtrahend or shift amount |
| res_o | output | 64 | Result |

## Verification
The bench targets the points where word and full-width behaviour differ. A word add whose sum crosses into bit 31 must come back with all upper bits set; a design that forgets to sign-extend returns a small positive number there. The shift-amount vectors set bits above the legal field, so a design that decodes too many amount bits shifts everything out and returns zero. Word right shifts use operands whose upper half is ones, which exposes a design that shifts the full 64-bit value. The fused cases set bit 31 of op_a, then clear it while setting other bits, and push op_b so the word sum wraps and changes sign. A design that shifts by the wrong amount, adds the full 64-bit value or skips sign extension gives a different result in at least one of these cases.

// File: rtl/fsa_alu_pkg.sv
package fsa_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_ADDW   = 4'd2,
    OP_SUBW   = 4'd3,
    OP_SLL    = 4'd4,
    OP_SRL    = 4'd5,
    OP_SRA    = 4'd6,
    OP_SLLW   = 4'd7,
    OP_SRLW   = 4'd8,
    OP_SRAW   = 4'd9,
    OP_LTS    = 4'd10,
    OP_LTU    = 4'd11,
    OP_SHADDW = 4'd12
  } alu_op_e;

endpackage

// File: rtl/fsa_addsub.sv
module fsa_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + W'(sub_i);
  end
endmodule

// File: rtl/fsa_shift.sv
module fsa_shift #(
  parameter int W = 64
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  input  logic                 left_i,
  input  logic                 arith_i,
  output logic [W-1:0]         res_o
);
  logic signed [W:0] ext;
  logic        [W:0] shr;

  always_comb begin
    ext   = {arith_i & data_i[W-1], data_i};
    shr   = ext >>> shamt_i;
    res_o = left_i ? (data_i << shamt_i) : shr[W-1:0];
  end
endmodule

// File: rtl/fsa_cmp.sv
module fsa_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  always_comb begin
    lt_s_o = $signed(a_i) < $signed(b_i);
    lt_u_o = a_i < b_i;
  end
endmodule

// File: rtl/fsa_alu.sv
module fsa_alu #(
  parameter int XLEN        = 64,
  parameter int WLEN        = 32,
  parameter int FUSED_SHAMT = 31
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o
);
  import fsa_alu_pkg::*;

  localparam int XSW = $clog2(XLEN);
  localparam int WSW = $clog2(WLEN);
  localparam int EXT = XLEN - WLEN;

  alu_op_e         op;
  logic [XLEN-1:0] fused_shr;
  logic [XLEN-1:0] add_a;
  logic            do_sub;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] sum_w;
  logic            sh_left;
  logic            sh_arith;
  logic [XLEN-1:0] shr_x;
  logic [WLEN-1:0] shr_w_raw;
  logic [XLEN-1:0] shr_w;
  logic            lt_s;
  logic            lt_u;

  always_comb begin
    op        = alu_op_e'(op_i);
    // fixed word right shift feeding the shared adder
    fused_shr = XLEN'(opa_i[WLEN-1:0] >> FUSED_SHAMT);
    add_a     = (op == OP_SHADDW) ? fused_shr : opa_i;
    do_sub    = (op == OP_SUB) || (op == OP_SUBW);
    sh_left   = (op == OP_SLL) || (op == OP_SLLW);
    sh_arith  = (op == OP_SRA) || (op == OP_SRAW);
  end

  fsa_addsub #(.W(XLEN)) u_add (
    .a_i   (add_a),
    .b_i   (opb_i),
    .sub_i (do_sub),
    .sum_o (sum)
  );

  fsa_shift #(.W(XLEN)) u_shx (
    .data_i  (opa_i),
    .shamt_i (opb_i[XSW-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .res_o   (shr_x)
  );

  fsa_shift #(.W(WLEN)) u_shw (
    .data_i  (opa_i[WLEN-1:0]),
    .shamt_i (opb_i[WSW-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .res_o   (shr_w_raw)
  );

  fsa_cmp #(.W(XLEN)) u_cmp (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  always_comb begin
    sum_w = {{EXT{sum[WLEN-1]}}, sum[WLEN-1:0]};
    shr_w = {{EXT{shr_w_raw[WLEN-1]}}, shr_w_raw};
    unique case (op)
      OP_ADD, OP_SUB:                 res_o = sum;
      OP_ADDW, OP_SUBW, OP_SHADDW:    res_o = sum_w;
      OP_SLL, OP_SRL, OP_SRA:         res_o = shr_x;
      OP_SLLW, OP_SRLW, OP_SRAW:      res_o = shr_w;
      OP_LTS:                         res_o = XLEN'(lt_s);
      OP_LTU:                         res_o = XLEN'(lt_u);
      default:                        res_o = '0;
    endcase
  end
endmodule

// File: rtl/fsa_alu_chk.sv
module fsa_alu_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic [3:0]      op_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [XLEN-1:0] res_o
);
  logic [WLEN-1:0] fused_delta;

  always_comb begin
    fused_delta = res_o[WLEN-1:0] - opb_i[WLEN-1:0];
    if (!$isunknown({op_i, opa_i, opb_i, res_o})) begin
      // R1
      sub_inverse_chk: assert (op_i != 4'd1 || (res_o + opb_i) == opa_i);
      // R2
      word_sext_chk: assert (!(op_i inside {4'd2, 4'd3, 4'd7, 4'd8, 4'd9, 4'd12})
                             || res_o[XLEN-1:WLEN] == {(XLEN-WLEN){res_o[WLEN-1]}});
      // R5
      cmp_bool_chk: assert (!(op_i inside {4'd10, 4'd11}) || res_o[XLEN-1:1] == '0);
      // R7
      fused_step_chk: assert (op_i != 4'd12 || fused_delta == WLEN'(opa_i[WLEN-1]));
      // R8
      bad_op_zero_chk: assert (op_i < 4'd13 || res_o == '0);
    end
  end
endmodule

bind fsa_alu fsa_alu_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .op_i  (op_i),
  .opa_i (opa_i),
  .opb_i (opb_i),
  .res_o (res_o)
);

// File: tb/fsa_alu_tb_top.sv
module fsa_alu_tb_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [63:0] a;
  logic [63:0] b;
  logic [63:0] res;
  int          n_chk;
  int          n_fail;
  bit          done;

  fsa_alu dut_i (
    .op_i  (op),
    .opa_i (a),
    .opb_i (b),
    .res_o (res)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // inputs change at the falling edge; result is read 1 ns later, before any rising edge (R9)
  task automatic run(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                     input logic [63:0] exp, input string req);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d got=%h exp=%h", req, o, res, exp);
    end
  endtask

  task automatic t_reset;
    run(4'd0, 64'd0, 64'd0, 64'd0, "R9");
  endtask

  task automatic t_add_sub;
    run(4'd0, 64'd5, 64'd7, 64'd12, "R1");
    run(4'd0, '1, 64'd1, 64'd0, "R1");
    run(4'd1, 64'd0, 64'd1, '1, "R1");
  endtask

  task automatic t_word_arith;
    run(4'd2, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, "R2");
    run(4'd2, 64'h1234_5678_0000_0001, 64'hABCD_0000_0000_0002, 64'd3, "R2");
    run(4'd3, 64'd0, 64'd1, '1, "R2");
  endtask

  task automatic t_shift64;
    run(4'd4, 64'd1, 64'd63, 64'h8000_0000_0000_0000, "R3");
    run(4'd4, 64'd1, 64'h41, 64'd2, "R3");
    run(4'd5, 64'h8000_0000_0000_0000, 64'd4, 64'h0800_0000_0000_0000, "R3");
    run(4'd6, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, "R3");
  endtask

  task automatic t_shiftw;
    run(4'd7, 64'd1, 64'd31, 64'hFFFF_FFFF_8000_0000, "R4");
    run(4'd7, 64'd3, 64'h21, 64'd6, "R4");
    run(4'd8, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'h0000_0000_0800_0000, "R4");
    run(4'd9, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000, "R4");
  endtask

  task automatic t_compare;
    run(4'd10, '1, 64'd1, 64'd1, "R5");
    run(4'd10, 64'd1, '1, 64'd0, "R5");
    run(4'd10, 64'd9, 64'd9, 64'd0, "R5");
    run(4'd11, '1, 64'd1, 64'd0, "R6");
    run(4'd11, 64'd1, '1, 64'd1, "R6");
  endtask

  task automatic t_fused;
    run(4'd12, 64'h8000_0000, 64'd5, 64'd6, "R7");
    run(4'd12, 64'h7FFF_FFFF, 64'd5, 64'd5, "R7");
    run(4'd12, 64'hFFFF_FFFF_0000_0000, 64'd9, 64'd9, "R7");
    run(4'd12, 64'h8000_0000, 64'h7FFF_FFFF, 64'hFFFF_FFFF_8000_0000, "R7");
    run(4'd12, 64'h8000_0000, 64'hFFFF_FFFF, 64'd0, "R7");
    run(4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_0010, 64'd17, "R7");
  endtask

  task automatic t_bad_op;
    for (int k = 13; k < 16; k++)
      run(4'(k), 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'd0, "R8");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    op = '0; a = '0; b = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add_sub();
    t_word_arith();
    t_shift64();
    t_shiftw();
    t_compare();
    t_fused();
    t_bad_op();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule